// File: doc/BRIEF.md
# Prefix-merging instruction decode stage

This block sits after the base decoder of a compact 16-bit instruction stream and in front of the wider internal operation format. Some 16-bit words are non-executing prefixes. A prefix never occupies an output slot. Instead, the block stores what the prefix says and folds it into the operation produced for the next ordinary instruction. This gives compact code shifted second operands, flag-setting forms, high-register operands, a third source register, immediates in place of a register, upper register-list halves and short predicated bursts, with no extra execute slot.

Most prefixes are one-shot: their stored data applies to the next ordinary instruction and is then discarded. Two kinds of context last longer. A predicate window covers a run of ordinary instructions taken in pairs. A bank selection chooses which half of the register file the 3-bit register fields reach, and it stays in force until it is changed. A flush input discards the instruction presented in the same cycle and clears all pending prefix state except the bank selection.

Top module: `pfx_coalescer`

## Requirements
- R1: An ordinary instruction accepted in a cycle (in_valid=1, in_is_prefix=0, flush=0) gives out_valid=1 with its merged fields at the next rising edge. A prefix gives out_valid=0 at the next edge. out_valid is 0 after reset.
- R2: When no prefix is pending and the bank is 0, out_rd/out_rn/out_rm equal the 3-bit inputs zero-extended to 4 bits. out_shtype, out_shamt, out_setflags, out_imm_en, out_three and out_third are 0, out_cond is 14 (always), out_list is in_list zero-extended, and out_opc equals in_opc.
- R3: A shift prefix (kind 0) sets out_shtype to arg[1:0] and out_shamt to arg[6:2] on the next ordinary instruction.
- R4: A flag prefix (kind 2) sets out_setflags to 1 on the next ordinary instruction.
- R5: A source prefix (kind 3) makes out_rn equal 8+arg[2:0]. A destination prefix (kind 4) makes out_rd equal 8+arg[2:0]. Both apply regardless of the bank.
- R6: A third-operand prefix (kind 5) sets out_third to arg[3:0] and out_three to 1.
- R7: An immediate prefix (kind 6) sets out_imm_en to 1 and out_imm to arg[11:0], and forces out_rm to 0.
- R8: An upper-list prefix (kind 7) applied to a register-list instruction (in_is_list=1) moves list bits 7:4 to out_list bits 11:8, clears bits 7:4 and keeps bits 3:0.
- R9: One-shot prefixes (kinds 0 and 2 to 7) affect exactly the next ordinary instruction and are cleared after it. Prefixes of different kinds all apply together. A later prefix of the same kind replaces the earlier one.
- R10: A predicate prefix (kind 1, condition arg[3:0], pair count arg[5:4]+1) opens a window of 2×pairs ordinary instructions. The first instruction of each pair gets out_cond=condition and the second gets the condition with bit 0 inverted. After the window, out_cond returns to 14. Prefixes inside the window do not use up window slots. A new predicate prefix restarts the window.
- R11: A bank prefix (kind 8) sets the bank to arg[0]. The bank persists across any number of instructions and is 0 after reset. With bank 1, register fields not overridden by a prefix come out as 8 plus the 3-bit field.
- R12: flush=1 discards the same-cycle input (out_valid=0 at the next edge) and clears the one-shot state and the predicate window. The bank selection is kept.
- R13: Prefix kinds 9 to 15 have no effect on later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard input and clear pending prefix state |
| in_valid | input | 1 | A decoded word is presented |
| in_is_prefix | input | 1 | The word is a prefix |
| in_kind | input | 4 | Prefix kind code |
| in_arg | input | 12 | Prefix argument |
| in_opc | input | OPC_W | Ordinary instruction operation code |
| in_rd | input | 3 | Destination register field |
| in_rn | input | 3 | First source / base register field |
| in_rm | input | 3 | Second source register field |
| in_is_list | input | 1 | Instruction carries a register list |
| in_list | input | 8 | Register list |
| out_valid | output | 1 | Merged operation valid |
| out_opc | output | OPC_W | Operation code |
| out_rd | output | 4 | Destination register |
| out_rn | output | 4 | First source register |
| out_rm | output | 4 | Second source register |
| out_third | output | 4 | Third source register |
| out_three | output | 1 | Third source register in use |
| out_shtype | output | 2 | Shift type on second operand |
| out_shamt | output | 5 | Shift amount |
| out_setflags | output | 1 | Update flags |
| out_imm_en | output | 1 | Immediate replaces second operand |
| out_imm | output | 12 | Immediate value |
| out_list | output | 16 | Register list over all 16 registers |
| out_cond | output | 4 | Execution condition, 14 = always |

## Verification
Each ordinary instruction's merged operation is due at the first rising edge after the cycle it is presented. A prefix or a flushed word shows out_valid low at that same edge. Prefix effects and context changes are therefore checked on the output of the following ordinary instruction, one edge after that instruction is presented. The bench drives each word on the falling edge and reads the outputs 1 ns after the rising edge that captures it, so every check reads the result of exactly the word just driven.

// File: rtl/pfx_pkg.sv
`timescale 1ns/1ps
package pfx_pkg;
    localparam int KIND_W  = 4;
    localparam int ARG_W   = 12;
    localparam int LREG_W  = 3;
    localparam int REG_W   = LREG_W + 1;
    localparam int LIST_W  = 8;
    localparam int HALF_W  = LIST_W / 2;
    localparam int XLIST_W = 2 * LIST_W;
    localparam int SHT_W   = 2;
    localparam int SHAMT_W = 5;
    localparam int COND_W  = 4;
    localparam int IMM_W   = ARG_W;

    localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

    typedef enum logic [KIND_W-1:0] {
        K_SHIFT = 4'd0,
        K_PRED  = 4'd1,
        K_SBIT  = 4'd2,
        K_SRC   = 4'd3,
        K_DST   = 4'd4,
        K_THIRD = 4'd5,
        K_IMM   = 4'd6,
        K_ALLHI = 4'd7,
        K_BANK  = 4'd8
    } pfx_kind_e;

    // pending one-shot prefix data
    typedef struct packed {
        logic               sh_v;
        logic [SHT_W-1:0]   sh_type;
        logic [SHAMT_W-1:0] sh_amt;
        logic               sbit;
        logic               src_v;
        logic [LREG_W-1:0]  src;
        logic               dst_v;
        logic [LREG_W-1:0]  dst;
        logic               thr_v;
        logic [REG_W-1:0]   thr;
        logic               imm_v;
        logic [IMM_W-1:0]   imm;
        logic               allhi;
    } shot_t;

    // fields of an ordinary instruction as decoded upstream
    typedef struct packed {
        logic [LREG_W-1:0] rd;
        logic [LREG_W-1:0] rn;
        logic [LREG_W-1:0] rm;
        logic              is_list;
        logic [LIST_W-1:0] list;
    } base_t;

    // merged wide operation fields
    typedef struct packed {
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rn;
        logic [REG_W-1:0]   rm;
        logic [REG_W-1:0]   thr;
        logic               three;
        logic [SHT_W-1:0]   sh_type;
        logic [SHAMT_W-1:0] sh_amt;
        logic               setflags;
        logic               imm_en;
        logic [IMM_W-1:0]   imm;
        logic [XLIST_W-1:0] list;
        logic [COND_W-1:0]  cond;
    } mop_t;
endpackage

// File: rtl/pfx_shot_store.sv
`timescale 1ns/1ps
module pfx_shot_store
    import pfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              take_pfx,
    input  logic              take_op,
    input  logic [KIND_W-1:0] kind,
    input  logic [ARG_W-1:0]  arg,
    output shot_t             shot_o
);
    shot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush || take_op) begin
            st_d = '0;
        end else if (take_pfx) begin
            case (kind)
                K_SHIFT: begin
                    st_d.sh_v    = 1'b1;
                    st_d.sh_type = arg[SHT_W-1:0];
                    st_d.sh_amt  = arg[SHT_W +: SHAMT_W];
                end
                K_SBIT:  st_d.sbit = 1'b1;
                K_SRC: begin
                    st_d.src_v = 1'b1;
                    st_d.src   = arg[LREG_W-1:0];
                end
                K_DST: begin
                    st_d.dst_v = 1'b1;
                    st_d.dst   = arg[LREG_W-1:0];
                end
                K_THIRD: begin
                    st_d.thr_v = 1'b1;
                    st_d.thr   = arg[REG_W-1:0];
                end
                K_IMM: begin
                    st_d.imm_v = 1'b1;
                    st_d.imm   = arg[IMM_W-1:0];
                end
                K_ALLHI: st_d.allhi = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shot_o = st_q;

    // R9: pending prefix data is gone once an instruction consumed it
    assert_clear_after_use_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_op |=> (st_q == '0));

    // R12: a flush leaves nothing pending
    assert_flush_clears_shot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q == '0));

    // R9: a stored shift stays until an instruction or flush arrives
    assert_shift_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sh_v && !take_op && !flush) |=> st_q.sh_v);
endmodule

// File: rtl/pfx_context.sv
`timescale 1ns/1ps
module pfx_context
    import pfx_pkg::*;
#(
    parameter int PAIR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     take_pfx,
    input  logic                     take_op,
    input  logic [KIND_W-1:0]        kind,
    input  logic [COND_W+PAIR_W-1:0] pred_arg,
    input  logic                     bank_sel,
    output logic                     bank_o,
    output logic [COND_W-1:0]        cond_o
);
    localparam int CNT_W = PAIR_W + 2;
    localparam logic [CNT_W-1:0] MAX_LEFT = CNT_W'(2 << PAIR_W);

    typedef struct packed {
        logic              bank;
        logic [CNT_W-1:0]  left;
        logic [COND_W-1:0] cond;
    } ctx_t;

    ctx_t c_d, c_q;
    logic [PAIR_W:0] pairs;

    always_comb begin
        pairs = {1'b0, pred_arg[COND_W +: PAIR_W]} + (PAIR_W+1)'(1);
        c_d   = c_q;
        if (flush) begin
            c_d.left = '0;
        end else if (take_pfx && kind == K_PRED) begin
            c_d.cond = pred_arg[COND_W-1:0];
            c_d.left = {pairs, 1'b0};
        end else if (take_pfx && kind == K_BANK) begin
            c_d.bank = bank_sel;
        end else if (take_op && c_q.left != '0) begin
            c_d.left = c_q.left - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // even remaining count: first of a pair; odd: second, inverted condition
    always_comb begin
        if (c_q.left == '0)  cond_o = COND_ALWAYS;
        else if (c_q.left[0]) cond_o = {c_q.cond[COND_W-1:1], ~c_q.cond[0]};
        else                  cond_o = c_q.cond;
    end

    assign bank_o = c_q.bank;

    // R10: window never longer than the largest pair count allows
    assert_window_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.left <= MAX_LEFT);

    // R10: each instruction in the window uses exactly one slot
    assert_window_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_op && !flush && c_q.left != '0) |=> (c_q.left == $past(c_q.left) - CNT_W'(1)));

    // R11: bank changes only through a bank prefix
    assert_bank_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_pfx && !flush && kind == K_BANK) |=> $stable(c_q.bank));

    // R12: flush closes the predicate window
    assert_flush_closes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (c_q.left == '0));
endmodule

// File: rtl/pfx_merge.sv
`timescale 1ns/1ps
module pfx_merge
    import pfx_pkg::*;
(
    input  base_t             base,
    input  shot_t             shot,
    input  logic              bank,
    input  logic [COND_W-1:0] cond,
    output mop_t              mop
);
    always_comb begin
        mop = '0;
        mop.rd = shot.dst_v ? {1'b1, shot.dst} : {bank, base.rd};
        mop.rn = shot.src_v ? {1'b1, shot.src} : {bank, base.rn};
        mop.rm = shot.imm_v ? '0 : {bank, base.rm};

        mop.three = shot.thr_v;
        mop.thr   = shot.thr_v ? shot.thr : '0;

        if (shot.sh_v) begin
            mop.sh_type = shot.sh_type;
            mop.sh_amt  = shot.sh_amt;
        end

        mop.setflags = shot.sbit;
        mop.imm_en   = shot.imm_v;
        mop.imm      = shot.imm_v ? shot.imm : '0;

        if (base.is_list && shot.allhi)
            mop.list = {{(XLIST_W-LIST_W-HALF_W){1'b0}}, base.list[LIST_W-1:HALF_W],
                        {HALF_W{1'b0}}, base.list[HALF_W-1:0]};
        else
            mop.list = {{(XLIST_W-LIST_W){1'b0}}, base.list};

        mop.cond = cond;
    end
endmodule

// File: rtl/pfx_coalescer.sv
`timescale 1ns/1ps
module pfx_coalescer
    import pfx_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter int PAIR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    input  logic               in_is_prefix,
    input  logic [KIND_W-1:0]  in_kind,
    input  logic [ARG_W-1:0]   in_arg,
    input  logic [OPC_W-1:0]   in_opc,
    input  logic [LREG_W-1:0]  in_rd,
    input  logic [LREG_W-1:0]  in_rn,
    input  logic [LREG_W-1:0]  in_rm,
    input  logic               in_is_list,
    input  logic [LIST_W-1:0]  in_list,
    output logic               out_valid,
    output logic [OPC_W-1:0]   out_opc,
    output logic [REG_W-1:0]   out_rd,
    output logic [REG_W-1:0]   out_rn,
    output logic [REG_W-1:0]   out_rm,
    output logic [REG_W-1:0]   out_third,
    output logic               out_three,
    output logic [SHT_W-1:0]   out_shtype,
    output logic [SHAMT_W-1:0] out_shamt,
    output logic               out_setflags,
    output logic               out_imm_en,
    output logic [IMM_W-1:0]   out_imm,
    output logic [XLIST_W-1:0] out_list,
    output logic [COND_W-1:0]  out_cond
);
    typedef struct packed {
        logic             vld;
        logic [OPC_W-1:0] opc;
        mop_t             mop;
    } outreg_t;

    logic              take_op, take_pfx;
    shot_t             shot;
    logic              bank;
    logic [COND_W-1:0] cond;
    base_t             base;
    mop_t              merged;
    outreg_t           o_d, o_q;

    assign take_op  = in_valid && !in_is_prefix && !flush;
    assign take_pfx = in_valid &&  in_is_prefix && !flush;

    assign base.rd      = in_rd;
    assign base.rn      = in_rn;
    assign base.rm      = in_rm;
    assign base.is_list = in_is_list;
    assign base.list    = in_list;

    pfx_shot_store u_shot (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .take_pfx (take_pfx),
        .take_op  (take_op),
        .kind     (in_kind),
        .arg      (in_arg),
        .shot_o   (shot)
    );

    pfx_context #(.PAIR_W(PAIR_W)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .take_pfx (take_pfx),
        .take_op  (take_op),
        .kind     (in_kind),
        .pred_arg (in_arg[COND_W+PAIR_W-1:0]),
        .bank_sel (in_arg[0]),
        .bank_o   (bank),
        .cond_o   (cond)
    );

    pfx_merge u_merge (
        .base (base),
        .shot (shot),
        .bank (bank),
        .cond (cond),
        .mop  (merged)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = take_op;
        if (take_op) begin
            o_d.opc = in_opc;
            o_d.mop = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid    = o_q.vld;
    assign out_opc      = o_q.opc;
    assign out_rd       = o_q.mop.rd;
    assign out_rn       = o_q.mop.rn;
    assign out_rm       = o_q.mop.rm;
    assign out_third    = o_q.mop.thr;
    assign out_three    = o_q.mop.three;
    assign out_shtype   = o_q.mop.sh_type;
    assign out_shamt    = o_q.mop.sh_amt;
    assign out_setflags = o_q.mop.setflags;
    assign out_imm_en   = o_q.mop.imm_en;
    assign out_imm      = o_q.mop.imm;
    assign out_list     = o_q.mop.list;
    assign out_cond     = o_q.mop.cond;

    // R1: a prefix never takes an output slot
    assert_prefix_no_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_prefix) |=> !out_valid);

    // R1: an accepted instruction appears one edge later
    assert_op_one_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_prefix && !flush) |=> (out_valid && out_opc == $past(in_opc)));

    // R12: flushed input produces no output
    assert_flush_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R7: an immediate always displaces the second register
    assert_imm_clears_rm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_imm_en) |-> (out_rm == '0));
endmodule

// File: tb/test_pfx_coalescer.sv
`timescale 1ns/1ps
module test_pfx_coalescer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_is_prefix = 1'b0;
    logic [3:0]  in_kind = '0;
    logic [11:0] in_arg = '0;
    logic [5:0]  in_opc = '0;
    logic [2:0]  in_rd = '0, in_rn = '0, in_rm = '0;
    logic        in_is_list = 1'b0;
    logic [7:0]  in_list = '0;
    logic        out_valid, out_three, out_setflags, out_imm_en;
    logic [5:0]  out_opc;
    logic [3:0]  out_rd, out_rn, out_rm, out_third, out_cond;
    logic [1:0]  out_shtype;
    logic [4:0]  out_shamt;
    logic [11:0] out_imm;
    logic [15:0] out_list;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pfx_coalescer i_pfx_coalescer (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_is_prefix(in_is_prefix), .in_kind(in_kind), .in_arg(in_arg),
        .in_opc(in_opc), .in_rd(in_rd), .in_rn(in_rn), .in_rm(in_rm),
        .in_is_list(in_is_list), .in_list(in_list), .out_valid(out_valid),
        .out_opc(out_opc), .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm),
        .out_third(out_third), .out_three(out_three), .out_shtype(out_shtype),
        .out_shamt(out_shamt), .out_setflags(out_setflags), .out_imm_en(out_imm_en),
        .out_imm(out_imm), .out_list(out_list), .out_cond(out_cond)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pfx(input int k, input int a);
        @(negedge clk);
        in_valid = 1'b1; in_is_prefix = 1'b1; in_kind = k[3:0]; in_arg = a[11:0];
        @(posedge clk); #1;
        in_valid = 1'b0; in_is_prefix = 1'b0;
    endtask

    task automatic op(input int opc, input int rd, input int rn, input int rm, input bit lst, input int list);
        @(negedge clk);
        in_valid = 1'b1; in_is_prefix = 1'b0; in_opc = opc[5:0];
        in_rd = rd[2:0]; in_rn = rn[2:0]; in_rm = rm[2:0];
        in_is_list = lst; in_list = list[7:0];
        @(posedge clk); #1;
        in_valid = 1'b0; in_is_list = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "out_valid after reset", out_valid, 0);
    endtask

    task automatic t_plain();
        op(6'h21, 3, 5, 6, 0, 8'h5A);
        chk("R1", "out_valid", out_valid, 1);
        chk("R2", "opc", out_opc, 6'h21);
        chk("R2", "rd", out_rd, 3);
        chk("R2", "rn", out_rn, 5);
        chk("R2", "rm", out_rm, 6);
        chk("R2", "cond", out_cond, 14);
        chk("R2", "shamt", out_shamt, 0);
        chk("R2", "flags", out_setflags, 0);
        chk("R2", "imm_en", out_imm_en, 0);
        chk("R2", "three", out_three, 0);
        chk("R2", "list", out_list, 16'h005A);
        pfx(2, 0);
        chk("R1", "prefix takes no slot", out_valid, 0);
        op(1, 0, 0, 0, 0, 0);   // consume pending flag prefix
    endtask

    task automatic t_shift();
        pfx(0, (2 << 2) | 2);
        op(2, 1, 2, 3, 0, 0);
        chk("R3", "shtype", out_shtype, 2);
        chk("R3", "shamt", out_shamt, 2);
        op(2, 1, 2, 3, 0, 0);
        chk("R9", "shift cleared", out_shamt, 0);
    endtask

    task automatic t_combo();
        pfx(2, 0);
        pfx(3, 1);
        pfx(4, 4);
        pfx(5, 11);
        pfx(6, 12'hABC);
        pfx(0, (5 << 2) | 1);
        pfx(0, (7 << 2) | 3);
        op(5, 0, 0, 7, 0, 0);
        chk("R4", "flags", out_setflags, 1);
        chk("R5", "rn source", out_rn, 9);
        chk("R5", "rd dest", out_rd, 12);
        chk("R6", "third", out_third, 11);
        chk("R6", "three", out_three, 1);
        chk("R7", "imm_en", out_imm_en, 1);
        chk("R7", "imm", out_imm, 12'hABC);
        chk("R7", "rm forced", out_rm, 0);
        chk("R9", "later shift type", out_shtype, 3);
        chk("R9", "later shift amt", out_shamt, 7);
        op(5, 2, 3, 7, 0, 0);
        chk("R9", "flags cleared", out_setflags, 0);
        chk("R9", "rd restored", out_rd, 2);
        chk("R9", "imm cleared", out_imm_en, 0);
        chk("R9", "rm restored", out_rm, 7);
    endtask

    task automatic t_allhigh();
        pfx(7, 0);
        op(9, 0, 0, 0, 1, 8'hF3);
        chk("R8", "upper list", out_list, 16'h0F03);
        op(9, 0, 0, 0, 1, 8'hF3);
        chk("R8", "plain list", out_list, 16'h00F3);
        pfx(7, 0);
        op(3, 0, 0, 0, 0, 8'hF0);
        op(9, 0, 0, 0, 1, 8'hF0);
        chk("R9", "upper list used up", out_list, 16'h00F0);
    endtask

    task automatic t_pred();
        pfx(1, (1 << 4) | 0);
        op(1, 0, 0, 0, 0, 0); chk("R10", "pair1 first", out_cond, 0);
        op(1, 0, 0, 0, 0, 0); chk("R10", "pair1 second", out_cond, 1);
        pfx(2, 0);
        op(1, 0, 0, 0, 0, 0); chk("R10", "prefix uses no slot", out_cond, 0);
        chk("R4", "flags inside window", out_setflags, 1);
        op(1, 0, 0, 0, 0, 0); chk("R10", "pair2 second", out_cond, 1);
        op(1, 0, 0, 0, 0, 0); chk("R10", "after window", out_cond, 14);
        pfx(1, 12'hB);
        op(1, 0, 0, 0, 0, 0); chk("R10", "cond B", out_cond, 4'hB);
        op(1, 0, 0, 0, 0, 0); chk("R10", "cond A", out_cond, 4'hA);
        op(1, 0, 0, 0, 0, 0); chk("R10", "one pair closed", out_cond, 14);
        pfx(1, (3 << 4) | 2);
        op(1, 0, 0, 0, 0, 0); chk("R10", "long window", out_cond, 2);
        pfx(1, 4);
        op(1, 0, 0, 0, 0, 0); chk("R10", "restart first", out_cond, 4);
        op(1, 0, 0, 0, 0, 0); chk("R10", "restart second", out_cond, 5);
        op(1, 0, 0, 0, 0, 0); chk("R10", "restart closed", out_cond, 14);
    endtask

    task automatic t_bank();
        pfx(8, 1);
        op(4, 3, 5, 6, 0, 0);
        chk("R11", "rd bank1", out_rd, 11);
        chk("R11", "rn bank1", out_rn, 13);
        chk("R11", "rm bank1", out_rm, 14);
        op(4, 3, 5, 6, 0, 0);
        chk("R11", "bank persists", out_rd, 11);
        pfx(4, 2);
        op(4, 3, 5, 6, 0, 0);
        chk("R5", "dest over bank", out_rd, 10);
        chk("R11", "rn still bank1", out_rn, 13);
        pfx(8, 0);
        op(4, 3, 5, 6, 0, 0);
        chk("R11", "bank0 again", out_rd, 3);
    endtask

    task automatic t_flush();
        pfx(8, 1);
        pfx(2, 0);
        pfx(1, (1 << 4) | 6);
        @(negedge clk);
        flush = 1'b1; in_valid = 1'b1; in_is_prefix = 1'b0;
        in_opc = 6'h3F; in_rd = 3; in_rn = 0; in_rm = 0;
        @(posedge clk); #1;
        flush = 1'b0; in_valid = 1'b0;
        chk("R12", "flushed input dropped", out_valid, 0);
        op(6'h11, 3, 1, 1, 0, 0);
        chk("R12", "flags cleared", out_setflags, 0);
        chk("R12", "window closed", out_cond, 14);
        chk("R12", "bank kept", out_rd, 11);
        pfx(8, 0);
    endtask

    task automatic t_unknown();
        pfx(12, 12'hFFF);
        pfx(9, 12'hFFF);
        op(7, 2, 4, 1, 1, 8'hF0);
        chk("R13", "rd", out_rd, 2);
        chk("R13", "rm", out_rm, 1);
        chk("R13", "flags", out_setflags, 0);
        chk("R13", "imm_en", out_imm_en, 0);
        chk("R13", "cond", out_cond, 14);
        chk("R13", "list", out_list, 16'h00F0);
        chk("R13", "shamt", out_shamt, 0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_plain();
        t_shift();
        t_combo();
        t_allhigh();
        t_pred();
        t_bank();
        t_flush();
        t_unknown();
        repeat (2) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule